// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Forms

This block is the combinational arithmetic stage of a 32-bit, three-operand integer pipeline. It takes one instruction word and the two register values already fetched for it. It returns the value to write back, the index of the destination register and a write strobe. It also reports which register indices the instruction reads, so the register file can be addressed from the same word.

The unit handles addition, subtraction, multiplication, the bitwise family, shifts, sign extension and six compares that yield 0 or 1. Most operations come in a register-register form and a register-immediate form. The 16-bit immediate is widened by a rule that depends on the opcode: sign extension for arithmetic and signed compares, zero extension for logical operations and unsigned compares, and placement in the upper half for the two "high" logical forms. Divide, modulus, loads, stores, branches, control-register access and custom instructions belong to other units. Their opcodes produce no write.

Top module: `int_exec_unit`

## Requirements
- R1: The opcode is instruction bits 31:26. The first source index is bits 25:21 and the second source index is bits 20:16. Register-register forms write the register named in bits 15:11.
- R2: Register-immediate forms use the 16-bit immediate in bits 15:0 in place of the second operand, and write the register named in bits 20:16.
- R3: Register opcodes 45, 50 and 34 give a+b, a-b and the low 32 bits of a*b, each modulo 2^32.
- R4: Register opcodes 40, 46, 38, 33 and 41 give AND, OR, XOR, NOR and XNOR of the two operands.
- R5: Opcodes 13 (add) and 2 (multiply) sign-extend their immediate from 16 bits.
- R6: Opcodes 8, 14, 6, 1 and 9 give AND, OR, XOR, NOR and XNOR of the first operand with the zero-extended immediate.
- R7: Opcode 24 ANDs and opcode 30 ORs the first operand with the immediate shifted left by 16.
- R8: The compares write 1 when true and 0 when false. Register/immediate opcode pairs: equal 57/25, signed greater 58/26, signed greater-or-equal 59/27, unsigned greater-or-equal 60/28, unsigned greater 61/29, not-equal 63/31. Immediates are sign-extended for 25, 26, 27 and 31, and zero-extended for 28 and 29.
- R9: The shifts are left (47, immediate 15), arithmetic right (37, immediate 5) and logical right (32, immediate 0). Each uses only the low 5 bits of the shift operand.
- R10: Opcode 44 copies bit 7 of the first operand into bits 31:8. Opcode 55 copies bit 15 into bits 31:16. The low bits pass through unchanged.
- R11: Register 0 is never written. The write strobe is low whenever the destination index is 0, which makes an add-immediate of 0 from register 0 to register 0 a no-operation.
- R12: Any opcode not listed above drives the write strobe low and the result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opnd_a_i | input | 32 | Value of the register named in bits 25:21 |
| opnd_b_i | input | 32 | Value of the register named in bits 20:16 |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| result_o | output | 32 | Value to write back |
| dest_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back strobe |

## Verification
The assertions check the following on every evaluation:
- compare results never exceed 1;
- a high-form operand has a zero lower half;
- a sum minus its second operand gives back the first operand;
- sign-extension results agree with the source bits;
- a write never targets register 0;
- an unrecognised opcode never raises the strobe.

Only the bench's sweep can show that each opcode picks the correct operation and extension rule, and that each form routes the correct destination field. The sweep covers every opcode against operand pairs at the sign and carry boundaries, immediates with either top bit, and shift operands wider than five bits.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int OPC_W  = 6;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 16;
  localparam int OPC_HI = 31;
  localparam int RS1_HI = 25;
  localparam int RS2_HI = 20;
  localparam int RD_HI  = 15;

  typedef enum logic [4:0] {
    ALU_ADD, ALU_SUB, ALU_MUL,
    ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_XNOR,
    ALU_SLL, ALU_SRA, ALU_SRL,
    ALU_SXB, ALU_SXH,
    ALU_CEQ, ALU_CNE, ALU_CGT, ALU_CGE, ALU_CGTU, ALU_CGEU
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_HIGH
  } src_mode_e;

  typedef struct packed {
    logic      valid;
    alu_op_e   op;
    src_mode_e src;
  } dec_t;

  function automatic dec_t mk(input alu_op_e op, input src_mode_e src);
    dec_t d;
    d.valid = 1'b1;
    d.op    = op;
    d.src   = src;
    return d;
  endfunction
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '{valid: 1'b0, op: ALU_ADD, src: SRC_REG};
    unique case (opcode_i)
      6'd45: dec_o = mk(ALU_ADD,  SRC_REG);
      6'd50: dec_o = mk(ALU_SUB,  SRC_REG);
      6'd34: dec_o = mk(ALU_MUL,  SRC_REG);
      6'd40: dec_o = mk(ALU_AND,  SRC_REG);
      6'd46: dec_o = mk(ALU_OR,   SRC_REG);
      6'd38: dec_o = mk(ALU_XOR,  SRC_REG);
      6'd33: dec_o = mk(ALU_NOR,  SRC_REG);
      6'd41: dec_o = mk(ALU_XNOR, SRC_REG);
      6'd47: dec_o = mk(ALU_SLL,  SRC_REG);
      6'd37: dec_o = mk(ALU_SRA,  SRC_REG);
      6'd32: dec_o = mk(ALU_SRL,  SRC_REG);
      6'd44: dec_o = mk(ALU_SXB,  SRC_REG);
      6'd55: dec_o = mk(ALU_SXH,  SRC_REG);
      6'd57: dec_o = mk(ALU_CEQ,  SRC_REG);
      6'd58: dec_o = mk(ALU_CGT,  SRC_REG);
      6'd59: dec_o = mk(ALU_CGE,  SRC_REG);
      6'd60: dec_o = mk(ALU_CGEU, SRC_REG);
      6'd61: dec_o = mk(ALU_CGTU, SRC_REG);
      6'd63: dec_o = mk(ALU_CNE,  SRC_REG);
      6'd13: dec_o = mk(ALU_ADD,  SRC_SEXT);
      6'd2:  dec_o = mk(ALU_MUL,  SRC_SEXT);
      6'd8:  dec_o = mk(ALU_AND,  SRC_ZEXT);
      6'd14: dec_o = mk(ALU_OR,   SRC_ZEXT);
      6'd6:  dec_o = mk(ALU_XOR,  SRC_ZEXT);
      6'd1:  dec_o = mk(ALU_NOR,  SRC_ZEXT);
      6'd9:  dec_o = mk(ALU_XNOR, SRC_ZEXT);
      6'd24: dec_o = mk(ALU_AND,  SRC_HIGH);
      6'd30: dec_o = mk(ALU_OR,   SRC_HIGH);
      6'd15: dec_o = mk(ALU_SLL,  SRC_SEXT);
      6'd5:  dec_o = mk(ALU_SRA,  SRC_SEXT);
      6'd0:  dec_o = mk(ALU_SRL,  SRC_SEXT);
      6'd25: dec_o = mk(ALU_CEQ,  SRC_SEXT);
      6'd26: dec_o = mk(ALU_CGT,  SRC_SEXT);
      6'd27: dec_o = mk(ALU_CGE,  SRC_SEXT);
      6'd28: dec_o = mk(ALU_CGEU, SRC_ZEXT);
      6'd29: dec_o = mk(ALU_CGTU, SRC_ZEXT);
      6'd31: dec_o = mk(ALU_CNE,  SRC_SEXT);
      default: ;
    endcase
  end
endmodule

// File: rtl/iexu_operand.sv
module iexu_operand
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  src_mode_e         mode_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    unique case (mode_i)
      SRC_SEXT: opnd_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      SRC_ZEXT: opnd_o = {{PAD_W{1'b0}}, imm_i};
      SRC_HIGH: opnd_o = {imm_i, {PAD_W{1'b0}}};
      default:  opnd_o = reg_i;
    endcase
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  logic            is_cmp;
  logic            eq, gts, gtu;

  assign shamt = b_i[SH_W-1:0];
  assign eq    = (a_i == b_i);
  assign gts   = ($signed(a_i) > $signed(b_i));
  assign gtu   = (a_i > b_i);
  assign is_cmp = op_i inside {ALU_CEQ, ALU_CNE, ALU_CGT, ALU_CGE, ALU_CGTU, ALU_CGEU};

  always_comb begin
    res_o = '0;
    unique case (op_i)
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_MUL:  res_o = a_i * b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_NOR:  res_o = ~(a_i | b_i);
      ALU_XNOR: res_o = ~(a_i ^ b_i);
      ALU_SLL:  res_o = a_i << shamt;
      ALU_SRA:  res_o = $unsigned($signed(a_i) >>> shamt);
      ALU_SRL:  res_o = a_i >> shamt;
      ALU_SXB:  res_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
      ALU_SXH:  res_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
      ALU_CEQ:  res_o[0] = eq;
      ALU_CNE:  res_o[0] = !eq;
      ALU_CGT:  res_o[0] = gts;
      ALU_CGE:  res_o[0] = gts | eq;
      ALU_CGTU: res_o[0] = gtu;
      ALU_CGEU: res_o[0] = gtu | eq;
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    if (is_cmp)
      assert_cmp_bool_R8: assert (res_o[DATA_W-1:1] == '0)
        else $error("compare result wider than one bit");
    if (op_i == ALU_ADD)
      assert_add_inverse_R3: assert (res_o - b_i == a_i)
        else $error("sum does not invert");
    if (op_i == ALU_SXB)
      assert_sxb_R10: assert ($signed(res_o) == $signed(a_i[7:0]))
        else $error("byte sign extension mismatch");
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  output logic [IDX_W-1:0]  rs1_idx_o,
  output logic [IDX_W-1:0]  rs2_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dest_idx_o,
  output logic              wr_en_o
);
  dec_t              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;

  assign rs1_idx_o = instr_i[RS1_HI -: IDX_W];
  assign rs2_idx_o = instr_i[RS2_HI -: IDX_W];

  iexu_decode u_dec (
    .opcode_i (instr_i[OPC_HI -: OPC_W]),
    .dec_o    (dec)
  );

  iexu_operand #(.DATA_W(DATA_W)) u_opnd (
    .mode_i (dec.src),
    .reg_i  (opnd_b_i),
    .imm_i  (instr_i[IMM_W-1:0]),
    .opnd_o (opnd_b)
  );

  iexu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (dec.op),
    .a_i   (opnd_a_i),
    .b_i   (opnd_b),
    .res_o (alu_res)
  );

  always_comb begin
    dest_idx_o = (dec.src == SRC_REG) ? instr_i[RD_HI -: IDX_W] : instr_i[RS2_HI -: IDX_W];
    wr_en_o    = dec.valid && (dest_idx_o != '0);
    result_o   = dec.valid ? alu_res : '0;
  end

  always_comb begin
    assert_no_r0_write_R11: assert (!(wr_en_o && dest_idx_o == '0))
      else $error("write to register 0");
    if (dec.src == SRC_HIGH)
      assert_high_low_zero_R7: assert (opnd_b[DATA_W-IMM_W-1:0] == '0)
        else $error("high immediate has nonzero low half");
    if (!dec.valid)
      assert_unknown_quiet_R12: assert (!wr_en_o)
        else $error("unknown opcode writes");
  end
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  logic        clk = 1'b0;
  logic [31:0] instr, a, b;
  logic [4:0]  rs1, rs2, dest;
  logic [31:0] result;
  logic        wr_en;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  int_exec_unit uut (
    .instr_i(instr), .opnd_a_i(a), .opnd_b_i(b),
    .rs1_idx_o(rs1), .rs2_idx_o(rs2),
    .result_o(result), .dest_idx_o(dest), .wr_en_o(wr_en)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d instr=%h a=%h b=%h actual=%h expected=%h",
               req, what, instr[31:26], instr, a, b, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb,
                       output logic v, output logic [4:0] d, output logic [31:0] r, output string req);
    logic [31:0] sx, zx, hi;
    logic        rr;
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    hi = {ins[15:0], 16'h0};
    v = 1'b1; rr = 1'b1; r = 32'h0; req = "R3";
    case (ins[31:26])
      6'd45: r = va + vb;
      6'd50: r = va - vb;
      6'd34: r = va * vb;
      6'd40: begin r = va & vb;    req = "R4"; end
      6'd46: begin r = va | vb;    req = "R4"; end
      6'd38: begin r = va ^ vb;    req = "R4"; end
      6'd33: begin r = ~(va | vb); req = "R4"; end
      6'd41: begin r = ~(va ^ vb); req = "R4"; end
      6'd47: begin r = va << vb[4:0]; req = "R9"; end
      6'd37: begin r = $unsigned($signed(va) >>> vb[4:0]); req = "R9"; end
      6'd32: begin r = va >> vb[4:0]; req = "R9"; end
      6'd44: begin r = {{24{va[7]}}, va[7:0]};   req = "R10"; end
      6'd55: begin r = {{16{va[15]}}, va[15:0]}; req = "R10"; end
      6'd57: begin r = {31'h0, va == vb}; req = "R8"; end
      6'd58: begin r = {31'h0, $signed(va) > $signed(vb)}; req = "R8"; end
      6'd59: begin r = {31'h0, $signed(va) >= $signed(vb)}; req = "R8"; end
      6'd60: begin r = {31'h0, va >= vb}; req = "R8"; end
      6'd61: begin r = {31'h0, va > vb}; req = "R8"; end
      6'd63: begin r = {31'h0, va != vb}; req = "R8"; end
      6'd13: begin r = va + sx; rr = 0; req = "R5"; end
      6'd2:  begin r = va * sx; rr = 0; req = "R5"; end
      6'd8:  begin r = va & zx;    rr = 0; req = "R6"; end
      6'd14: begin r = va | zx;    rr = 0; req = "R6"; end
      6'd6:  begin r = va ^ zx;    rr = 0; req = "R6"; end
      6'd1:  begin r = ~(va | zx); rr = 0; req = "R6"; end
      6'd9:  begin r = ~(va ^ zx); rr = 0; req = "R6"; end
      6'd24: begin r = va & hi; rr = 0; req = "R7"; end
      6'd30: begin r = va | hi; rr = 0; req = "R7"; end
      6'd15: begin r = va << ins[4:0]; rr = 0; req = "R9"; end
      6'd5:  begin r = $unsigned($signed(va) >>> ins[4:0]); rr = 0; req = "R9"; end
      6'd0:  begin r = va >> ins[4:0]; rr = 0; req = "R9"; end
      6'd25: begin r = {31'h0, va == sx}; rr = 0; req = "R8"; end
      6'd26: begin r = {31'h0, $signed(va) > $signed(sx)}; rr = 0; req = "R8"; end
      6'd27: begin r = {31'h0, $signed(va) >= $signed(sx)}; rr = 0; req = "R8"; end
      6'd28: begin r = {31'h0, va >= zx}; rr = 0; req = "R8"; end
      6'd29: begin r = {31'h0, va > zx}; rr = 0; req = "R8"; end
      6'd31: begin r = {31'h0, va != sx}; rr = 0; req = "R8"; end
      default: begin v = 1'b0; req = "R12"; end
    endcase
    d = rr ? ins[15:11] : ins[20:16];
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb);
    logic v; logic [4:0] d; logic [31:0] r; string req; string dreq;
    @(posedge clk);
    instr = ins; a = va; b = vb;
    @(negedge clk);
    model(ins, va, vb, v, d, r, req);
    dreq = (req == "R12") ? "R12" : (d == 5'd0 ? "R11" : "R2");
    if (ins[31:26] inside {45, 50, 34, 40, 46, 38, 33, 41, 47, 37, 32, 44, 55, 57, 58, 59, 60, 61, 63})
      dreq = (d == 5'd0) ? "R11" : "R1";
    chk(req, "result", result, r);
    chk(dreq, "dest", {27'h0, dest}, {27'h0, d});
    chk(dreq, "wr_en", {31'h0, wr_en}, {31'h0, v && d != 5'd0});
    chk("R1", "rs1", {27'h0, rs1}, {27'h0, ins[25:21]});
    chk("R1", "rs2", {27'h0, rs2}, {27'h0, ins[20:16]});
  endtask

  logic [31:0] pats [8];
  logic [15:0] imms [6];

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001;
    pats[2] = 32'h7FFF_FFFF; pats[3] = 32'h8000_0000;
    pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h0000_0080;
    pats[6] = 32'h1234_8765; pats[7] = 32'h0000_0021;
    imms[0] = 16'h0000; imms[1] = 16'h7FFF; imms[2] = 16'h8001;
    imms[3] = 16'hFFFF; imms[4] = 16'h0021; imms[5] = 16'h07C5;
    instr = 32'h0; a = 32'h0; b = 32'h0;
    // R11: the no-operation encoding writes nothing
    apply({6'd13, 5'd0, 5'd0, 16'h0}, 32'h0, 32'h0);
    for (int op = 0; op < 64; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int ii = 0; ii < 6; ii++) begin
            logic [4:0] fb;
            fb = 5'((op * 7 + ia * 3 + ib * 5 + ii) % 32);
            apply({6'(op), 5'(ia + 3), fb, imms[ii]}, pats[ia], pats[ib]);
          end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule